// File: doc/BRIEF.md
# Segmented Virtually Addressed Cache Lookup

This block is the tag, valid and data storage of a data cache built from 8 segments of 64 lines, each line carrying eight 32-bit words. Address bits [7:5] name the one segment that takes part in an access. The position of a line inside that segment has nothing to do with the address. A lookup therefore compares the address tag, bits [31:8], against all 64 stored tags of the chosen segment at once. It then reports hit or miss, the index of the matching line, and the read data narrowed to the access size.

A separate fill port writes a whole line (tag, eight words, valid bit) into a segment and index chosen by the caller. The caller also owns victim choice, fetching lines from memory and any write policy. A flush input drops every line at once. Lookup results appear one clock after the request.

Top module: `seg_cache`

## Requirements
- R1: After reset every line is invalid and `rsp_valid_o`, `rsp_hit_o`, `rsp_index_o` and `rsp_data_o` are all zero.
- R2: `rsp_valid_o` is high in exactly the cycle after a cycle with `lk_valid_i` high. Without a request, `rsp_hit_o` stays low.
- R3: A lookup hits only when a valid line of segment `lk_addr_i[7:5]` holds a tag equal to `lk_addr_i[31:8]`. A valid line with that tag in any other segment gives a miss.
- R4: On a hit, `rsp_index_o` is the index (0..63) of the matching line. If several lines of the segment match, it is the lowest such index.
- R5: For a word access (`lk_size_i` 2 or 3), `rsp_data_o` is word `lk_addr_i[4:2]` of the hit line. Word k of a line is bits [32k+31:32k] of `fill_data_i`.
- R6: For a halfword access (`lk_size_i` = 1), `rsp_data_o` is the upper half of the selected word when `lk_addr_i[1]` is 1 and the lower half otherwise. The value is zero-extended to 32 bits.
- R7: For a byte access (`lk_size_i` = 0), `rsp_data_o` is byte `lk_addr_i[1:0]` of the selected word, where byte b is bits [8b+7:8b]. The value is zero-extended.
- R8: On a miss, `rsp_data_o` and `rsp_index_o` are zero.
- R9: A fill with `fill_valid_i` high stores tag `fill_addr_i[31:8]`, all eight words and a set valid bit at segment `fill_addr_i[7:5]`, index `fill_index_i`. It replaces any older content of that line, and `fill_addr_i[4:0]` is ignored. A lookup in the same cycle as a fill sees the line as it was before the fill.
- R10: `flush_i` invalidates every line in one cycle. A fill in the same cycle as a flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all lines |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | 32 | Lookup virtual address |
| lk_size_i | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| fill_valid_i | input | 1 | Line write strobe |
| fill_addr_i | input | 32 | Fill address (tag and segment) |
| fill_index_i | input | 6 | Target line index within the segment |
| fill_data_i | input | 256 | Eight words of line data, word 0 lowest |
| rsp_valid_o | output | 1 | Lookup result valid |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_index_o | output | 6 | Index of hitting line |
| rsp_data_o | output | 32 | Read data, aligned and zero-extended |

## Verification
A corrupted tag, valid bit or data word is only seen when a lookup touches that line. It shows up one cycle later as a wrong hit flag, a wrong index or wrong data. For this reason the bench keeps a full model of all 512 lines and checks every response against it. It draws tags from a small pool, so hits, duplicate tags within a segment and equal tags across segments happen often. A flush or fill that lands in the wrong place goes unseen until a later lookup of the affected segment. Directed checks that follow a flush, or a fill that coincides with a lookup or flush, catch such faults on the very next response.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD2 = 2'd3
  } acc_size_e;
endpackage

// File: rtl/seg_tag_store.sv
module seg_tag_store #(
  parameter int NUM_SEG   = 8,
  parameter int NUM_LINES = 64,
  parameter int TAG_W     = 24,
  localparam int SEG_W    = $clog2(NUM_SEG),
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flush_i,
  input  logic                 fill_en_i,
  input  logic [SEG_W-1:0]     fill_seg_i,
  input  logic [IDX_W-1:0]     fill_idx_i,
  input  logic [TAG_W-1:0]     fill_tag_i,
  input  logic [SEG_W-1:0]     lk_seg_i,
  input  logic [TAG_W-1:0]     lk_tag_i,
  output logic [NUM_LINES-1:0] match_o
);
  logic [TAG_W-1:0]     tag_q   [NUM_SEG][NUM_LINES];
  logic [NUM_LINES-1:0] valid_q [NUM_SEG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SEG; s++) valid_q[s] <= '0;
    end else if (flush_i) begin
      for (int s = 0; s < NUM_SEG; s++) valid_q[s] <= '0;
    end else if (fill_en_i) begin
      valid_q[fill_seg_i][fill_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i && !flush_i) tag_q[fill_seg_i][fill_idx_i] <= fill_tag_i;
  end

  // all lines of the selected segment compared in parallel
  logic [NUM_LINES-1:0] seg_valid;
  assign seg_valid = valid_q[lk_seg_i];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_cmp
    assign match_o[i] = seg_valid[i] && (tag_q[lk_seg_i][i] == lk_tag_i);
  end

  logic any_valid;
  always_comb begin
    any_valid = 1'b0;
    for (int s = 0; s < NUM_SEG; s++) any_valid = any_valid | (|valid_q[s]);
  end

  AST_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !any_valid); // R10
  AST_FILL_SETS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en_i && !flush_i) |=> valid_q[$past(fill_seg_i)][$past(fill_idx_i)]); // R9
endmodule

// File: rtl/seg_match_enc.sv
module seg_match_enc #(
  parameter int NUM_LINES = 64,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] match_i,
  output logic                 hit_o,
  output logic [IDX_W-1:0]     idx_o
);
  // lowest matching index wins
  always_comb begin
    idx_o = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (match_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign hit_o = |match_i;

  always_comb begin
    if (hit_o) assert (match_i[idx_o]); // R4
  end
endmodule

// File: rtl/seg_data_store.sv
module seg_data_store #(
  parameter int NUM_SEG   = 8,
  parameter int NUM_LINES = 64,
  parameter int WORDS     = 8,
  parameter int DATA_W    = 32,
  localparam int SEG_W    = $clog2(NUM_SEG),
  localparam int IDX_W    = $clog2(NUM_LINES),
  localparam int WSEL_W   = $clog2(WORDS),
  localparam int LINE_W   = WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [SEG_W-1:0]  wr_seg_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  logic [SEG_W-1:0]  rd_seg_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [WSEL_W-1:0] rd_word_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [LINE_W-1:0] line_q [NUM_SEG][NUM_LINES];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) line_q[wr_seg_i][wr_idx_i] <= wr_line_i;
  end

  logic [LINE_W-1:0] rd_line;
  assign rd_line   = line_q[rd_seg_i][rd_idx_i];
  assign rd_data_o = rd_line[rd_word_i*DATA_W +: DATA_W];
endmodule

// File: rtl/seg_lane_sel.sv
module seg_lane_sel
  import cache_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(DATA_W / 8)
) (
  input  logic [DATA_W-1:0] word_i,
  input  acc_size_e         size_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] shifted;
  assign shifted = word_i >> {off_i, 3'b000};

  always_comb begin
    unique case (size_i)
      SZ_BYTE: data_o = {{(DATA_W-8){1'b0}}, shifted[7:0]};
      SZ_HALF: data_o = off_i[OFF_W-1] ? {{HALF_W{1'b0}}, word_i[DATA_W-1:HALF_W]}
                                       : {{HALF_W{1'b0}}, word_i[HALF_W-1:0]};
      default: data_o = word_i;
    endcase
  end
endmodule

// File: rtl/seg_cache.sv
module seg_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_SEG   = 8,
  parameter int NUM_LINES = 64,
  parameter int WORDS     = 8,
  localparam int SEG_W    = $clog2(NUM_SEG),
  localparam int IDX_W    = $clog2(NUM_LINES),
  localparam int WSEL_W   = $clog2(WORDS),
  localparam int OFF_W    = $clog2(DATA_W / 8),
  localparam int WSEL_LSB = OFF_W,
  localparam int SEG_LSB  = OFF_W + WSEL_W,
  localparam int TAG_LSB  = SEG_LSB + SEG_W,
  localparam int TAG_W    = ADDR_W - TAG_LSB,
  localparam int LINE_W   = WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              lk_valid_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic [1:0]        lk_size_i,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [IDX_W-1:0]  fill_index_i,
  input  logic [LINE_W-1:0] fill_data_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [IDX_W-1:0]  rsp_index_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  logic [SEG_W-1:0]  lk_seg, fill_seg;
  logic [TAG_W-1:0]  lk_tag, fill_tag;
  logic [WSEL_W-1:0] lk_word;
  logic [OFF_W-1:0]  lk_off;
  logic              fill_en;

  assign lk_seg   = lk_addr_i[SEG_LSB +: SEG_W];
  assign lk_tag   = lk_addr_i[TAG_LSB +: TAG_W];
  assign lk_word  = lk_addr_i[WSEL_LSB +: WSEL_W];
  assign lk_off   = lk_addr_i[OFF_W-1:0];
  assign fill_seg = fill_addr_i[SEG_LSB +: SEG_W];
  assign fill_tag = fill_addr_i[TAG_LSB +: TAG_W];
  assign fill_en  = fill_valid_i && !flush_i;

  logic [NUM_LINES-1:0] match;
  logic                 hit;
  logic [IDX_W-1:0]     hit_idx;
  logic [DATA_W-1:0]    rd_word, lane_data;

  seg_tag_store #(.NUM_SEG(NUM_SEG), .NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) i_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .fill_en_i  (fill_en),
    .fill_seg_i (fill_seg),
    .fill_idx_i (fill_index_i),
    .fill_tag_i (fill_tag),
    .lk_seg_i   (lk_seg),
    .lk_tag_i   (lk_tag),
    .match_o    (match)
  );

  seg_match_enc #(.NUM_LINES(NUM_LINES)) i_enc (
    .match_i (match),
    .hit_o   (hit),
    .idx_o   (hit_idx)
  );

  seg_data_store #(.NUM_SEG(NUM_SEG), .NUM_LINES(NUM_LINES), .WORDS(WORDS), .DATA_W(DATA_W)) i_data (
    .clk_i     (clk_i),
    .wr_en_i   (fill_en),
    .wr_seg_i  (fill_seg),
    .wr_idx_i  (fill_index_i),
    .wr_line_i (fill_data_i),
    .rd_seg_i  (lk_seg),
    .rd_idx_i  (hit_idx),
    .rd_word_i (lk_word),
    .rd_data_o (rd_word)
  );

  seg_lane_sel #(.DATA_W(DATA_W)) i_lane (
    .word_i (rd_word),
    .size_i (acc_size_e'(lk_size_i)),
    .off_i  (lk_off),
    .data_o (lane_data)
  );

  logic lk_hit;
  assign lk_hit = lk_valid_i && hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_index_o <= '0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= lk_valid_i;
      rsp_hit_o   <= lk_hit;
      rsp_index_o <= lk_hit ? hit_idx : '0;
      rsp_data_o  <= lk_hit ? lane_data : '0;
    end
  end

  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_data_o == '0 && rsp_index_o == '0)); // R8
  AST_NO_REQ_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !rsp_hit_o); // R2
  AST_BYTE_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && lk_size_i == 2'd0) |=> (rsp_data_o[DATA_W-1:8] == '0)); // R7
  AST_HALF_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && lk_size_i == 2'd1) |=> (rsp_data_o[DATA_W-1:DATA_W/2] == '0)); // R6
endmodule

// File: tb/test_seg_cache.sv
`timescale 1ns/1ps
module test_seg_cache;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         flush_i = 1'b0;
  logic         lk_valid_i = 1'b0;
  logic [31:0]  lk_addr_i = '0;
  logic [1:0]   lk_size_i = '0;
  logic         fill_valid_i = 1'b0;
  logic [31:0]  fill_addr_i = '0;
  logic [5:0]   fill_index_i = '0;
  logic [255:0] fill_data_i = '0;
  logic         rsp_valid_o, rsp_hit_o;
  logic [5:0]   rsp_index_o;
  logic [31:0]  rsp_data_o;

  always #2.5 clk_i = ~clk_i;

  seg_cache i_seg_cache (.*);

  logic [23:0]  m_tag   [8][64];
  bit           m_valid [8][64];
  logic [255:0] m_data  [8][64];
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [23:0] pool [4];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_fill(input logic [31:0] a, input logic [5:0] idx, input logic [255:0] d);
    m_tag[a[7:5]][idx] = a[31:8];
    m_valid[a[7:5]][idx] = 1'b1;
    m_data[a[7:5]][idx] = d;
  endtask

  task automatic model_lookup(input logic [31:0] a, input logic [1:0] sz,
                              output bit h, output logic [5:0] ix, output logic [31:0] d);
    logic [31:0] w;
    h = 0; ix = 0; d = 0;
    for (int i = 63; i >= 0; i--)
      if (m_valid[a[7:5]][i] && m_tag[a[7:5]][i] == a[31:8]) begin h = 1; ix = 6'(i); end
    if (h) begin
      w = m_data[a[7:5]][ix][32*a[4:2] +: 32];
      case (sz)
        2'd0: d = (w >> (8 * a[1:0])) & 32'hff;
        2'd1: d = a[1] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
        default: d = w;
      endcase
    end
  endtask

  function automatic string data_req(input bit h, input logic [1:0] sz);
    if (!h) return "R8";
    if (sz == 2'd0) return "R7";
    if (sz == 2'd1) return "R6";
    return "R5";
  endfunction

  // drive lookup (and optionally a fill in the same cycle); starts and ends at negedge
  task automatic access(input logic [31:0] a, input logic [1:0] sz, input bit do_fill,
                        input logic [31:0] fa, input logic [5:0] fi, input logic [255:0] fd,
                        input string hit_req);
    bit h; logic [5:0] ix; logic [31:0] d;
    model_lookup(a, sz, h, ix, d);
    lk_valid_i = 1; lk_addr_i = a; lk_size_i = sz;
    fill_valid_i = do_fill; fill_addr_i = fa; fill_index_i = fi; fill_data_i = fd;
    @(negedge clk_i);
    lk_valid_i = 0; fill_valid_i = 0;
    if (do_fill) model_fill(fa, fi, fd);
    chk("R2", {31'b0, rsp_valid_o}, 32'd1);
    chk(hit_req, {31'b0, rsp_hit_o}, {31'b0, h});
    chk(h ? "R4" : "R8", {26'b0, rsp_index_o}, {26'b0, ix});
    chk(data_req(h, sz), rsp_data_o, d);
  endtask

  task automatic lookup(input logic [31:0] a, input logic [1:0] sz, input string hit_req);
    access(a, sz, 0, 32'h0, 6'h0, 256'h0, hit_req);
  endtask

  task automatic fill(input logic [31:0] a, input logic [5:0] idx, input logic [255:0] d);
    fill_valid_i = 1; fill_addr_i = a; fill_index_i = idx; fill_data_i = d;
    @(negedge clk_i);
    fill_valid_i = 0;
    model_fill(a, idx, d);
  endtask

  function automatic logic [255:0] rnd_line();
    logic [255:0] l;
    for (int k = 0; k < 8; k++) l[32*k +: 32] = $urandom;
    return l;
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int s = 0; s < 8; s++) for (int i = 0; i < 64; i++) m_valid[s][i] = 0;
    for (int p = 0; p < 4; p++) pool[p] = 24'($urandom);
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", {31'b0, rsp_valid_o}, 0);
    chk("R1", {31'b0, rsp_hit_o}, 0);
    chk("R1", {26'b0, rsp_index_o}, 0);
    chk("R1", rsp_data_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    lookup({pool[0], 3'd2, 5'd0}, 2, "R1");

    // R2 idle cycle yields no response
    @(negedge clk_i);
    chk("R2", {31'b0, rsp_valid_o}, 0);
    chk("R2", {31'b0, rsp_hit_o}, 0);

    // R5 word reads, all word slots; R9 offset bits ignored on fill
    fill({pool[1], 3'd3, 5'h1f}, 6'd40, rnd_line());
    for (int w = 0; w < 8; w++) lookup({pool[1], 3'd3, 3'(w), 2'b00}, 2, "R3");
    lookup({pool[1], 3'd3, 3'd5, 2'b00}, 3, "R3");
    // R6 halfwords, R7 bytes
    for (int b = 0; b < 4; b++) lookup({pool[1], 3'd3, 3'd6, 2'(b)}, 0, "R3");
    for (int b = 0; b < 4; b += 2) lookup({pool[1], 3'd3, 3'd2, 2'(b)}, 1, "R3");
    // R3 same tag, other segment misses
    lookup({pool[1], 3'd4, 3'd0, 2'b00}, 2, "R3");
    // R4 duplicate tag: lowest index wins
    fill({pool[1], 3'd3, 5'h0}, 6'd63, rnd_line());
    fill({pool[1], 3'd3, 5'h0}, 6'd7, rnd_line());
    lookup({pool[1], 3'd3, 3'd1, 2'b00}, 2, "R4");
    // R9 overwrite changes tag of index 7
    fill({pool[2], 3'd3, 5'h0}, 6'd7, rnd_line());
    lookup({pool[1], 3'd3, 3'd1, 2'b00}, 2, "R9");
    lookup({pool[2], 3'd3, 3'd1, 2'b00}, 2, "R9");
    // R9 lookup coincident with fill sees old state
    access({pool[3], 3'd0, 3'd4, 2'b00}, 2, 1, {pool[3], 3'd0, 5'h0}, 6'd0, rnd_line(), "R9");
    lookup({pool[3], 3'd0, 3'd4, 2'b00}, 2, "R9");

    // R10 flush clears all, fill during flush dropped
    flush_i = 1;
    fill_valid_i = 1; fill_addr_i = {pool[0], 3'd1, 5'h0}; fill_index_i = 6'd9; fill_data_i = rnd_line();
    @(negedge clk_i);
    flush_i = 0; fill_valid_i = 0;
    for (int s = 0; s < 8; s++) for (int i = 0; i < 64; i++) m_valid[s][i] = 0;
    lookup({pool[0], 3'd1, 3'd0, 2'b00}, 2, "R10");
    lookup({pool[1], 3'd3, 3'd0, 2'b00}, 2, "R10");
    lookup({pool[3], 3'd0, 3'd4, 2'b00}, 2, "R10");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int op = $urandom_range(0, 9);
      logic [31:0] a = {pool[$urandom_range(0, 3)], 8'($urandom)};
      if (op < 4) fill(a, 6'($urandom), rnd_line());
      else if (op == 4) access({pool[$urandom_range(0, 3)], 8'($urandom)}, 2'($urandom), 1,
                               a, 6'($urandom), rnd_line(), "R9");
      else if (op == 5 && n % 500 == 0) begin
        flush_i = 1; @(negedge clk_i); flush_i = 0;
        for (int s = 0; s < 8; s++) for (int i = 0; i < 64; i++) m_valid[s][i] = 0;
      end
      else lookup(a, 2'($urandom), "R3");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule